// File: doc/BRIEF.md
# Per-Block Flash Protection Lock Unit

This unit keeps the protection state of a flash array divided into uniform blocks (sixteen by default). It screens every access against that state. Each block owns a small lock register with three control bits: a write-protect bit, a read-protect bit and a sticky freeze bit. Once the freeze bit is set, the block's register can no longer be changed until the next reset. Host logic reads and writes these registers through a simple indexed register port.

Program and erase requests pass through a check port. The port takes a target block index and answers at once, in the same cycle, whether the change is allowed. When a request is refused, the port also raises an error flag that the status register can capture. The per-block write-protect bit is combined by OR with three hardware overrides:
- a low-supply indication, which covers every block;
- an active-low pin that covers only the top block;
- an active-low pin that covers all the other blocks.

A read filter sits between the array and the bus. It forces the data to zero for read-protected blocks and passes it through unchanged for all others.

Top module: `blk_lock_unit`

## Requirements
- R1: After a synchronous reset, every block reads back as write-protect = 1, freeze = 0 and read-protect = 0, so `cfg_rdata` returns 8'h01 for every index.
- R2: The lock register layout is bit 0 = write-protect, bit 1 = freeze, bit 2 = read-protect. Bits 7:3 always read as zero, and writes to them are ignored. `cfg_rdata` shows the register selected by `cfg_idx` combinationally.
- R3: When `cfg_we` is high and the selected block's freeze bit is 0, that block's three bits take `cfg_wdata[2:0]` at the next clock edge. No other block changes.
- R4: While a block's freeze bit is 1, register writes to that block leave all three of its bits unchanged.
- R5: Reset clears the freeze bit, so a block that was frozen becomes writable again after reset.
- R6: `mod_allow` is 0 exactly when the block at `mod_idx` is write-protected. `mod_err` equals `mod_req` AND NOT `mod_allow`. Both respond within the same cycle.
- R7: While `supply_low` is 1, every block is write-protected, whatever its write-protect bit holds.
- R8: While `top_prot_n` is 0, the top block (index NUM_BLK-1) is write-protected. The other blocks are not affected by this pin.
- R9: While `main_prot_n` is 0, blocks 0 to NUM_BLK-2 are write-protected. The top block is not affected by this pin.
- R10: `rd_data` is 8'h00 when the block at `rd_idx` has read-protect = 1. Otherwise it equals `arr_data`, combinationally.
- R11: A modify check in the same cycle as a register write judges the block by its state before that write. The new state applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 4 | Block selected for register read and write |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Lock register of the selected block |
| mod_idx | input | 4 | Target block of a program or erase |
| mod_req | input | 1 | Program or erase request present |
| mod_allow | output | 1 | Target block may be modified |
| mod_err | output | 1 | Request refused, error for the status register |
| rd_idx | input | 4 | Block being read from the array |
| arr_data | input | 8 | Data coming from the array |
| rd_data | output | 8 | Filtered read data |
| supply_low | input | 1 | Programming supply below lockout level |
| top_prot_n | input | 1 | Active-low protect for the top block |
| main_prot_n | input | 1 | Active-low protect for all other blocks |

## Verification
A register write to a block can land in the same cycle as a program check on that same block. The check must then reflect the old lock bits, and the new bits must appear only from the next cycle. The bench provokes this by clearing a block's write-protect bit while a request for that block is pending. It expects a refusal with the error flag in that cycle and an allow in the next. The reference model, updated only at the clock edge, judges every cycle. A second collision is also exercised: a write arriving at a frozen block while its register and read filter are being observed. Here no output may change.

// File: rtl/flk_pkg.sv
package flk_pkg;
  // positions of the control bits inside one lock register
  localparam int unsigned BIT_WR   = 0;
  localparam int unsigned BIT_DOWN = 1;
  localparam int unsigned BIT_RD   = 2;
  localparam int unsigned CTRL_W   = 3;

  typedef struct packed {
    logic rd;
    logic down;
    logic wr;
  } lock_bits_t;
endpackage

// File: rtl/flk_lock_bank.sv
module flk_lock_bank
  import flk_pkg::*;
#(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  lock_bits_t         wr_bits,
  output logic [NUM_BLK-1:0] wl_v,
  output logic [NUM_BLK-1:0] ld_v,
  output logic [NUM_BLK-1:0] rl_v
);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        wl_v[g] <= 1'b1;
        ld_v[g] <= 1'b0;
        rl_v[g] <= 1'b0;
      end else if (sel && !ld_v[g]) begin
        wl_v[g] <= wr_bits.wr;
        ld_v[g] <= wr_bits.down;
        rl_v[g] <= wr_bits.rd;
      end
    end

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      ld_v[g] |=> ($stable(wl_v[g]) && $stable(rl_v[g]) && ld_v[g])); // R4

    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst)
      (sel && !ld_v[g]) |=> ({rl_v[g], ld_v[g], wl_v[g]} == $past(wr_bits))); // R3
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (wl_v == '1 && ld_v == '0 && rl_v == '0)); // R1 R5

endmodule

// File: rtl/flk_wp_guard.sv
module flk_wp_guard #(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BLK-1:0] wl_v,
  input  logic               supply_low,
  input  logic               top_prot_n,
  input  logic               main_prot_n,
  input  logic [IDX_W-1:0]   chk_idx,
  input  logic               chk_req,
  output logic               chk_allow,
  output logic               chk_err
);
  localparam int unsigned TOP_BLK = NUM_BLK - 1;

  logic [NUM_BLK-1:0] pin_cover;
  logic [NUM_BLK-1:0] wp_eff;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_cov
    if (g == TOP_BLK) begin : g_top
      assign pin_cover[g] = !top_prot_n;
    end else begin : g_main
      assign pin_cover[g] = !main_prot_n;
    end
  end

  assign wp_eff    = wl_v | pin_cover | {NUM_BLK{supply_low}};
  assign chk_allow = !wp_eff[chk_idx];
  assign chk_err   = chk_req && wp_eff[chk_idx];

  AST_LOCKBIT_DENY: assert property (@(posedge clk) disable iff (rst)
    wl_v[chk_idx] |-> !chk_allow); // R6
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !chk_req |-> !chk_err); // R6
  AST_SUPPLY_DENY: assert property (@(posedge clk) disable iff (rst)
    supply_low |-> !chk_allow); // R7
  AST_TOP_PIN: assert property (@(posedge clk) disable iff (rst)
    (!top_prot_n && chk_idx == IDX_W'(TOP_BLK)) |-> !chk_allow); // R8
  AST_MAIN_PIN: assert property (@(posedge clk) disable iff (rst)
    (!main_prot_n && chk_idx != IDX_W'(TOP_BLK)) |-> !chk_allow); // R9

endmodule

// File: rtl/flk_rd_mask.sv
module flk_rd_mask #(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BLK),
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BLK-1:0] rl_v,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [DATA_W-1:0]  arr_data,
  output logic [DATA_W-1:0]  rd_data
);
  assign rd_data = rl_v[rd_idx] ? '0 : arr_data;

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rl_v[rd_idx] |-> (rd_data == '0)); // R10
  AST_RD_PASS: assert property (@(posedge clk) disable iff (rst)
    !rl_v[rd_idx] |-> (rd_data == arr_data)); // R10

endmodule

// File: rtl/blk_lock_unit.sv
module blk_lock_unit
  import flk_pkg::*;
#(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_BLK),
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [IDX_W-1:0]  mod_idx,
  input  logic              mod_req,
  output logic              mod_allow,
  output logic              mod_err,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              supply_low,
  input  logic              top_prot_n,
  input  logic              main_prot_n
);
  logic [NUM_BLK-1:0] wl_v, ld_v, rl_v;
  lock_bits_t         wr_bits;
  lock_bits_t         sel_bits;
  logic               unused_wdata_hi;

  assign wr_bits.wr   = cfg_wdata[BIT_WR];
  assign wr_bits.down = cfg_wdata[BIT_DOWN];
  assign wr_bits.rd   = cfg_wdata[BIT_RD];
  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:CTRL_W];

  flk_lock_bank #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_bits(wr_bits),
    .wl_v(wl_v), .ld_v(ld_v), .rl_v(rl_v)
  );

  flk_wp_guard #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_guard (
    .clk(clk), .rst(rst), .wl_v(wl_v), .supply_low(supply_low),
    .top_prot_n(top_prot_n), .main_prot_n(main_prot_n),
    .chk_idx(mod_idx), .chk_req(mod_req), .chk_allow(mod_allow), .chk_err(mod_err)
  );

  flk_rd_mask #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .rl_v(rl_v), .rd_idx(rd_idx),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  assign sel_bits.wr   = wl_v[cfg_idx];
  assign sel_bits.down = ld_v[cfg_idx];
  assign sel_bits.rd   = rl_v[cfg_idx];
  assign cfg_rdata     = DATA_W'(sel_bits);

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-1:CTRL_W] == '0); // R2

endmodule

// File: tb/blk_lock_unit_bench.sv
module blk_lock_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_idx = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] mod_idx = '0;
  logic       mod_req = 1'b0;
  logic       mod_allow, mod_err;
  logic [3:0] rd_idx = '0;
  logic [7:0] arr_data = '0;
  logic [7:0] rd_data;
  logic       supply_low = 1'b0;
  logic       top_prot_n = 1'b1;
  logic       main_prot_n = 1'b1;

  int n_run = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  bit m_wl[16];
  bit m_ld[16];
  bit m_rl[16];

  always #2 clk = ~clk;

  blk_lock_unit u_blk_lock_unit (
    .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mod_idx(mod_idx), .mod_req(mod_req), .mod_allow(mod_allow),
    .mod_err(mod_err), .rd_idx(rd_idx), .arr_data(arr_data), .rd_data(rd_data),
    .supply_low(supply_low), .top_prot_n(top_prot_n), .main_prot_n(main_prot_n)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_wp(int i);
    bit pin;
    pin = (i == 15) ? !top_prot_n : !main_prot_n;
    return m_wl[i] | supply_low | pin;
  endfunction

  // one cycle: check outputs mid-cycle, then advance the model at the edge
  task automatic cyc(string tag);
    bit wp;
    #1;
    if (chk_en) begin
      wp = exp_wp(int'(mod_idx));
      chk(tag, "cfg_rdata(R2)", cfg_rdata,
          {5'b0, m_rl[cfg_idx], m_ld[cfg_idx], m_wl[cfg_idx]});
      chk(tag, "mod_allow(R6)", {7'b0, mod_allow}, {7'b0, !wp});
      chk(tag, "mod_err(R6)", {7'b0, mod_err}, {7'b0, mod_req & wp});
      chk(tag, "rd_data(R10)", rd_data, m_rl[rd_idx] ? 8'h00 : arr_data);
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        m_wl[i] = 1'b1; m_ld[i] = 1'b0; m_rl[i] = 1'b0;
      end
    end else if (cfg_we && !m_ld[cfg_idx]) begin
      m_wl[cfg_idx] = cfg_wdata[0];
      m_ld[cfg_idx] = cfg_wdata[1];
      m_rl[cfg_idx] = cfg_wdata[2];
    end
    @(negedge clk);
  endtask

  task automatic wr(int idx, logic [7:0] d, string tag);
    cfg_idx = 4'(idx); cfg_we = 1'b1; cfg_wdata = d;
    cyc(tag);
    cfg_we = 1'b0;
    cyc(tag);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) begin
      cfg_idx = 4'(i); mod_idx = 4'(i); rd_idx = 4'(i);
      arr_data = 8'(8'h31 + i * 7);
      cyc(tag);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc("R1");
    chk_en = 1'b1;
    cyc("R1");
    rst = 1'b0;
    mod_req = 1'b1;
    sweep("R1");
    // R2: upper bits ignored, control bits cleared
    wr(3, 8'hF8, "R2");
    sweep("R2");
    // R3 / R10: read-protect set, write-protect cleared on block 5
    rd_idx = 4'd5; arr_data = 8'h5A;
    wr(5, 8'h04, "R3");
    mod_idx = 4'd5; cfg_idx = 4'd5; cyc("R10");
    sweep("R3");
    // R4: freeze block 7 with write-protect cleared, then try to change it
    wr(7, 8'h02, "R4");
    rd_idx = 4'd7; arr_data = 8'hC3;
    wr(7, 8'h05, "R4");
    wr(7, 8'h07, "R4");
    cfg_idx = 4'd7; mod_idx = 4'd7; cyc("R4");
    // R11: clear write-protect on block 9 while a request targets it
    mod_idx = 4'd9; mod_req = 1'b1;
    cfg_idx = 4'd9; cfg_we = 1'b1; cfg_wdata = 8'h00;
    cyc("R11");
    cfg_we = 1'b0;
    cyc("R11");
    // open every block for the override tests
    for (int i = 0; i < 16; i++) wr(i, 8'h00, "R3");
    sweep("R3");
    supply_low = 1'b1; sweep("R7"); supply_low = 1'b0;
    top_prot_n = 1'b0; sweep("R8"); top_prot_n = 1'b1;
    main_prot_n = 1'b0; sweep("R9"); main_prot_n = 1'b1;
    mod_req = 1'b0; sweep("R6");
    mod_req = 1'b1;
    // R5: reset releases the freeze on block 7
    rst = 1'b1; cyc("R5");
    rst = 1'b0;
    cfg_idx = 4'd7; mod_idx = 4'd7; cyc("R5");
    wr(7, 8'h04, "R5");
    rd_idx = 4'd7; arr_data = 8'h99; cyc("R5");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule